// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice

This block is a purely combinational arithmetic and logic unit assembled from identical four-bit slices. A three-bit select picks one of eight functions: three arithmetic ones (A plus B, A minus B, B minus A), three bitwise ones (XOR, OR, AND), and two constant ones that force the result to all zeros or all ones. The arithmetic path adds a carry input to the result and produces a carry output and a two's-complement overflow flag.

Subtraction is computed as the minuend plus the bitwise inverse of the subtrahend plus the carry input. The unit does not add the +1 itself. To get the exact difference, the caller drives the carry input high. To get the difference minus one, the caller leaves it low.

A parameter sets how many slices are chained. Each slice's carry output feeds the next slice's carry input, and only the least significant slice sees the external carry input. The carry output and the overflow flag come from the most significant slice.

Top module: `alu_chain`

## Requirements
- R1: Select code 000 drives every result bit to 0, and select code 111 drives every result bit to 1.
- R2: Select code 001 gives result = (B + ~A + carry_in) mod 2^W. carry_out is bit W of that sum.
- R3: Select code 011 gives result = (A + B + carry_in) mod 2^W. carry_out is bit W of that sum.
- R4: Select code 010 gives result = (A + ~B + carry_in) mod 2^W. carry_out is bit W of that sum. With carry_in = 1 this is the exact difference A - B, and carry_out = 1 means no borrow occurred.
- R5: Select codes 100, 101 and 110 give the bitwise A XOR B, A OR B and A AND B respectively.
- R6: For select codes 000, 100, 101, 110 and 111, carry_out, overflow and every internal slice carry and slice overflow are 0.
- R7: In the three arithmetic codes, overflow is 1 exactly when the signed two's-complement value of the operation (including carry_in) lies outside the range of a W-bit signed number. This equals the XOR of the carry into and the carry out of the most significant bit.
- R8: For N_SLICES slices, W = 4*N_SLICES. The carries ripple from slice to slice, and the chain behaves as one W-bit unit under R1 to R7. Only the least significant slice receives carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | Operand A |
| op_b | input | W | Operand B |
| func_sel | input | 3 | Function select code |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | W | Function result |
| carry_out | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Two's-complement overflow of the most significant slice |

## Verification
The assertions assume the inputs are settled, known values. Each one holds for any combination of operands, select code and carry input, so none of them constrains the stimulus. The single-slice instance is swept over every select code, every operand pair and both carry values. The 16-bit chain is driven with directed sign-boundary and ripple-through cases plus random operands, and carry_in is deliberately varied in the subtract modes to cover both the exact difference and the difference minus one.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;

  typedef enum logic [2:0] {
    SEL_CLEAR   = 3'b000,
    SEL_B_SUB_A = 3'b001,
    SEL_A_SUB_B = 3'b010,
    SEL_ADD     = 3'b011,
    SEL_XOR     = 3'b100,
    SEL_OR      = 3'b101,
    SEL_AND     = 3'b110,
    SEL_PRESET  = 3'b111
  } alu_sel_e;

  // The arithmetic codes sit together in the 001..011 range.
  function automatic logic sel_is_arith(alu_sel_e s);
    return (s == SEL_B_SUB_A) || (s == SEL_A_SUB_B) || (s == SEL_ADD);
  endfunction

  // B minus A: operands swap, and A becomes the inverted subtrahend.
  function automatic logic sel_swaps(alu_sel_e s);
    return s == SEL_B_SUB_A;
  endfunction

  function automatic logic sel_inverts(alu_sel_e s);
    return (s == SEL_B_SUB_A) || (s == SEL_A_SUB_B);
  endfunction

endpackage

// File: rtl/alu_slice_adder.sv
module alu_slice_adder #(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] x_in,
  input  logic [SLICE_W-1:0] y_in,
  input  logic               c_in,
  output logic [SLICE_W-1:0] sum,
  output logic               c_into_msb,
  output logic               c_out
);
  localparam int LOW_W = SLICE_W - 1;

  logic [LOW_W:0] low_ext;
  logic [1:0]     top_ext;

  // The low bits and the MSB are added separately, so the carry into the MSB is visible.
  assign low_ext = {1'b0, x_in[LOW_W-1:0]} + {1'b0, y_in[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, c_in};
  assign c_into_msb = low_ext[LOW_W];
  assign top_ext = {1'b0, x_in[SLICE_W-1]} + {1'b0, y_in[SLICE_W-1]} + {1'b0, c_into_msb};
  assign sum   = {top_ext[0], low_ext[LOW_W-1:0]};
  assign c_out = top_ext[1];
endmodule

// File: rtl/alu_slice_logic.sv
module alu_slice_logic
  import alu_chain_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_in,
  input  logic [SLICE_W-1:0] b_in,
  input  alu_sel_e           sel,
  output logic [SLICE_W-1:0] y
);
  always_comb begin
    unique case (sel)
      SEL_XOR:    y = a_in ^ b_in;
      SEL_OR:     y = a_in | b_in;
      SEL_AND:    y = a_in & b_in;
      SEL_PRESET: y = '1;
      default:    y = '0;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_chain_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_in,
  input  logic [SLICE_W-1:0] b_in,
  input  alu_sel_e           sel,
  input  logic               c_in,
  output logic [SLICE_W-1:0] f_out,
  output logic               c_out,
  output logic               ovf
);
  logic               arith_mode;
  logic [SLICE_W-1:0] x_op, y_op, y_raw, add_sum, logic_y;
  logic               add_c_msb, add_c_out;

  assign arith_mode = sel_is_arith(sel);
  assign x_op  = sel_swaps(sel) ? b_in : a_in;
  assign y_raw = sel_swaps(sel) ? a_in : b_in;
  assign y_op  = sel_inverts(sel) ? ~y_raw : y_raw;

  alu_slice_adder #(.SLICE_W(SLICE_W)) u_adder (
    .x_in(x_op), .y_in(y_op), .c_in(c_in),
    .sum(add_sum), .c_into_msb(add_c_msb), .c_out(add_c_out)
  );

  alu_slice_logic #(.SLICE_W(SLICE_W)) u_logic (
    .a_in(a_in), .b_in(b_in), .sel(sel), .y(logic_y)
  );

  assign f_out = arith_mode ? add_sum : logic_y;
  assign c_out = arith_mode & add_c_out;
  assign ovf   = arith_mode & (add_c_msb ^ add_c_out);
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_chain_pkg::*;
#(
  parameter int N_SLICES = 4,
  parameter int SLICE_W  = 4
) (
  input  logic [N_SLICES*SLICE_W-1:0] op_a,
  input  logic [N_SLICES*SLICE_W-1:0] op_b,
  input  logic [2:0]                  func_sel,
  input  logic                        carry_in,
  output logic [N_SLICES*SLICE_W-1:0] result,
  output logic                        carry_out,
  output logic                        overflow
);
  localparam int W = N_SLICES * SLICE_W;

  alu_sel_e            sel_e;
  logic [N_SLICES:0]   ripple;
  logic [N_SLICES-1:0] slice_ovf;

  assign sel_e     = alu_sel_e'(func_sel);
  assign ripple[0] = carry_in;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    alu_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a_in (op_a[i*SLICE_W +: SLICE_W]),
      .b_in (op_b[i*SLICE_W +: SLICE_W]),
      .sel  (sel_e),
      .c_in (ripple[i]),
      .f_out(result[i*SLICE_W +: SLICE_W]),
      .c_out(ripple[i+1]),
      .ovf  (slice_ovf[i])
    );
  end

  assign carry_out = ripple[N_SLICES];
  assign overflow  = slice_ovf[N_SLICES-1];
endmodule

// File: rtl/alu_chain_chk.sv
module alu_chain_chk #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   func_sel,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow,
  input logic [N:0]   ripple,
  input logic [N-1:0] slice_ovf
);
  logic [W:0] add_ref, amb_ref;
  logic       arith, sa, sb, sr;

  assign add_ref = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign amb_ref = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, carry_in};
  assign arith = (func_sel == 3'b001) || (func_sel == 3'b010) || (func_sel == 3'b011);
  assign sa = op_a[W-1];
  assign sb = op_b[W-1];
  assign sr = result[W-1];

  always_comb begin
    if (func_sel == 3'b000) AST_CLEAR_ZERO: assert (result == '0);          // R1
    if (func_sel == 3'b111) AST_PRESET_ONES: assert (result == '1);         // R1
    if (func_sel == 3'b011) AST_ADD_SUM: assert ({carry_out, result} == add_ref); // R3
    if (func_sel == 3'b010) AST_A_SUB_B: assert ({carry_out, result} == amb_ref); // R4
    if (func_sel == 3'b100) AST_XOR_BITS: assert (result == (op_a ^ op_b)); // R5
    if (!arith) AST_QUIET_FLAGS: assert (!carry_out && !overflow && slice_ovf == '0 && ripple[N:1] == '0); // R6
    if (func_sel == 3'b011) AST_OVF_ADD: assert (overflow == ((sa == sb) && (sr != sa)));   // R7
    if (func_sel == 3'b010) AST_OVF_AMB: assert (overflow == ((sa != sb) && (sr != sa)));   // R7
    if (func_sel == 3'b001) AST_OVF_BMA: assert (overflow == ((sa != sb) && (sr != sb)));   // R7
  end
endmodule

bind alu_chain alu_chain_chk #(.W(N_SLICES*SLICE_W), .N(N_SLICES)) u_chk (
  .op_a(op_a), .op_b(op_b), .func_sel(func_sel), .carry_in(carry_in),
  .result(result), .carry_out(carry_out), .overflow(overflow),
  .ripple(ripple), .slice_ovf(slice_ovf)
);

// File: tb/alu_chain_bench.sv
module alu_chain_bench;
  localparam int WB = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [WB-1:0] a16, b16, f16;
  logic [WS-1:0] a4, b4, f4;
  logic [2:0]    s16, s4;
  logic          c16, c4, co16, co4, ov16, ov4;

  int vectors = 0;
  int checks  = 0;
  int fails   = 0;
  bit done    = 0;

  alu_chain #(.N_SLICES(4), .SLICE_W(4)) u_alu_chain (
    .op_a(a16), .op_b(b16), .func_sel(s16), .carry_in(c16),
    .result(f16), .carry_out(co16), .overflow(ov16));

  alu_chain #(.N_SLICES(1), .SLICE_W(4)) u_alu_chain_one (
    .op_a(a4), .op_b(b4), .func_sel(s4), .carry_in(c4),
    .result(f4), .carry_out(co4), .overflow(ov4));

  function automatic string sel_tag(int s);
    case (s)
      0, 7:    return "R1";
      1:       return "R2";
      2:       return "R4";
      3:       return "R3";
      default: return "R5";
    endcase
  endfunction

  // Arithmetic reference: unsigned sum for result/carry, signed sum for overflow.
  task automatic model(input int w, input int s, input int a, input int b, input int ci,
                       output int f, output int co, output int ov);
    int mask, half, sa, sb, u, sv;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    sa = (a >= half) ? a - (1 << w) : a;
    sb = (b >= half) ? b - (1 << w) : b;
    co = 0; ov = 0; u = 0; sv = 0;
    case (s)
      0: f = 0;
      7: f = mask;
      4: f = a ^ b;
      5: f = a | b;
      6: f = a & b;
      default: begin
        if (s == 3)      begin u = a + b + ci;          sv = sa + sb + ci;     end
        else if (s == 2) begin u = a + (mask - b) + ci; sv = sa - sb - 1 + ci; end
        else             begin u = b + (mask - a) + ci; sv = sb - sa - 1 + ci; end
        f  = u & mask;
        co = u >> w;
        ov = (sv < -half || sv > half - 1) ? 1 : 0;
      end
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_vec(input int w, input int s, input int a, input int b, input int ci,
                           input int f, input int co, input int ov, input bit chain);
    int ef, eco, eov;
    string t;
    model(w, s, a, b, ci, ef, eco, eov);
    t = chain ? "R8" : sel_tag(s);
    check(t, "result", f, ef);
    check((s >= 1 && s <= 3) ? t : "R6", "carry_out", co, eco);
    check((s >= 1 && s <= 3) ? "R7" : "R6", "overflow", ov, eov);
  endtask

  task automatic run_one(input int s, input int a, input int b, input int ci);
    @(posedge clk);
    s4 = 3'(s); a4 = 4'(a); b4 = 4'(b); c4 = 1'(ci);
    @(negedge clk);
    vectors++;
    check_vec(WS, s, a, b, ci, int'(f4), int'(co4), int'(ov4), 1'b0);
  endtask

  task automatic run_chain(input int s, input int a, input int b, input int ci);
    @(posedge clk);
    s16 = 3'(s); a16 = 16'(a); b16 = 16'(b); c16 = 1'(ci);
    @(negedge clk);
    vectors++;
    check_vec(WB, s, a, b, ci, int'(f16), int'(co16), int'(ov16), 1'b1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    a16 = '0; b16 = '0; s16 = '0; c16 = 1'b0;
    a4 = '0; b4 = '0; s4 = '0; c4 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // State right after reset with clear selected: all outputs low (R1, R6).
    check("R1", "reset result", int'(f16), 0);
    check("R6", "reset flags", int'({co16, ov16}), 0);

    // Exhaustive sweep of one slice: R1..R7.
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int ci = 0; ci < 2; ci++)
            run_one(s, a, b, ci);

    // 16-bit chain boundaries (R8, R7).
    run_chain(3, 'h7FFF, 'h0001, 0);  // positive overflow
    run_chain(3, 'hFFFF, 'h0000, 1);  // carry ripples through all slices
    run_chain(3, 'h8000, 'h8000, 0);  // negative overflow, carry out
    run_chain(2, 'h8000, 'h0001, 1);  // A-B overflow
    run_chain(2, 'h1234, 'h1234, 1);  // exact zero, no borrow
    run_chain(2, 'h1234, 'h1234, 0);  // difference minus one
    run_chain(1, 'h0001, 'h8000, 1);  // B-A overflow
    run_chain(0, 'hFFFF, 'hFFFF, 1);
    run_chain(7, 'h0000, 'h0000, 0);

    for (int k = 0; k < 3000; k++)
      run_chain(int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
                int'($urandom_range(0, 65535)), int'($urandom_range(0, 1)));

    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end
endmodule